// File: doc/BRIEF.md
# Selectable-Source Clock Divider Cell

This cell builds one output clock from a primary source clock and a bank of eight secondary source clocks. A source stage either passes the primary clock through or picks one secondary clock by a 3-bit index. The picked clock then goes to a divide stage. That stage has three paths: a pass-through, a programmable divider whose ratio comes from a coded table, and a fixed divide-by-3 path that overrides the other two. An enable gate sits at the output.

All control bits are static configuration inputs, driven from registers elsewhere in the chip. A new divide setting is not applied at once. It is loaded only when the current output period ends, so a change never shortens a pulse. The ratio currently in force is driven on an output port so that it can be checked. Two parameters remove the source stage and the enable gate for instances that do not need them.

Top module: `clk_div_cell`

## Requirements
- R1: With `src_sw` = 0 the cell runs from `clk_pri`, and `src_sel` has no effect on the output period.
- R2: With `src_sw` = 1 the cell runs from `clk_sec[k]`, where k is the value on `src_sel`.
- R3: With `div3_sw` = 0 and `div_sw` = 1, the 3-bit `div_sel` code sets the ratio. Code 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 6, 4 gives 8 and 5 gives 12. Codes 6 and 7 both give 1. `ratio_o` reports the ratio in force as an unsigned number.
- R4: With `div3_sw` = 1 the ratio is 3 whatever `div_sw` and `div_sel` hold. The output is then high for one source cycle and low for two.
- R5: With `div3_sw` = 0 and `div_sw` = 0 the ratio is 1, and the output follows the source clock.
- R6: For even ratios the output has a 50% duty cycle. Each phase lasts ratio/2 source cycles and the output rises at the start of each period.
- R7: A change to the divide controls takes effect only after the current output period ends. That period keeps its old length, and the next period uses the new ratio.
- R8: With `enable` = 0 the output is held low. With `enable` = 1 the divided clock appears, and the gate changes state only while the divided clock is low.
- R9: With `HAS_MUX` = 0 only `clk_pri` is used. With `HAS_GATE` = 0 the output runs whatever `enable` holds.
- R10: While `rst` is high, `clk_out` is low and `ratio_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary source clock |
| clk_sec | input | 8 | Secondary source clocks |
| rst | input | 1 | Synchronous active-high reset, sampled on the selected source clock |
| src_sw | input | 1 | 0: primary source, 1: secondary source |
| src_sel | input | 3 | Index of the secondary source |
| div_sw | input | 1 | 0: bypass the programmable divider |
| div_sel | input | 3 | Ratio code for the programmable divider |
| div3_sw | input | 1 | 1: fixed divide-by-3 path, which overrides the other divide settings |
| enable | input | 1 | Output gate enable |
| clk_out | output | 1 | Output clock |
| ratio_o | output | 4 | Ratio currently in force |

## Verification
A new divide setting reaches `ratio_o` and the output waveform at the first source edge that ends an output period. That is one source edge later when the ratio in force is 1, and up to the full old period later otherwise. So after each configuration change the bench lets three whole output periods go by before it measures. It measures the period and the high time between edges of `clk_out` itself, and reads `ratio_o` one nanosecond after a rising output edge, well away from any source edge. The runt test times the period that spans a change and checks that it keeps its old length. The gate test waits forty source cycles before it samples the output at many points in time.

// File: rtl/cdc_pkg.sv
`timescale 1ps/1ps
package cdc_pkg;
    localparam int N_SEC = 8;
    localparam int SEL_W = 3;
    localparam int RAT_W = 4;

    typedef struct packed {
        logic       div3_on;
        logic       div_on;
        logic [2:0] code;
    } div_cfg_t;

    // Ratio selected by a set of divide controls.
    function automatic logic [RAT_W-1:0] eff_ratio(div_cfg_t c);
        if (c.div3_on) return RAT_W'(3);
        if (!c.div_on) return RAT_W'(1);
        case (c.code)
            3'd0:    return RAT_W'(1);
            3'd1:    return RAT_W'(2);
            3'd2:    return RAT_W'(4);
            3'd3:    return RAT_W'(6);
            3'd4:    return RAT_W'(8);
            3'd5:    return RAT_W'(12);
            default: return RAT_W'(1);
        endcase
    endfunction

    // Number of source cycles the output stays high in each period.
    function automatic logic [RAT_W-1:0] high_len(logic [RAT_W-1:0] r);
        if (r <= RAT_W'(3)) return RAT_W'(1);
        return r >> 1;
    endfunction
endpackage

// File: rtl/cdc_src_mux.sv
`timescale 1ps/1ps
module cdc_src_mux
    import cdc_pkg::*;
#(
    parameter bit HAS_MUX = 1'b1
) (
    input  logic             clk_pri,
    input  logic [N_SEC-1:0] clk_sec,
    input  logic             src_sw,
    input  logic [SEL_W-1:0] src_sel,
    output logic             clk_sel
);
    generate
        if (HAS_MUX) begin : g_mux
            assign clk_sel = src_sw ? clk_sec[src_sel] : clk_pri;
        end else begin : g_nomux
            logic unused_src;
            assign unused_src = ^{clk_sec, src_sw, src_sel};
            assign clk_sel    = clk_pri;
        end
    endgenerate
endmodule

// File: rtl/cdc_div_core.sv
`timescale 1ps/1ps
module cdc_div_core
    import cdc_pkg::*;
#(
    parameter int CNT_W = RAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  div_cfg_t         cfg,
    output logic [CNT_W-1:0] cnt,
    output logic [RAT_W-1:0] ratio,
    output logic             phase_q,
    output logic             div_clk
);
    localparam int NW = CNT_W + 1;

    logic [NW-1:0] cnt_nxt;
    logic          period_end;

    assign cnt_nxt    = NW'(cnt) + NW'(1);
    assign period_end = cnt_nxt >= NW'(ratio);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ratio   <= RAT_W'(1);
            phase_q <= 1'b0;
        end else if (period_end) begin
            cnt     <= '0;
            ratio   <= eff_ratio(cfg);
            phase_q <= 1'b1;
        end else begin
            cnt     <= cnt_nxt[CNT_W-1:0];
            phase_q <= cnt_nxt < NW'(high_len(ratio));
        end
    end

    // At ratio 1 the source clock itself is forwarded.
    assign div_clk = (ratio == RAT_W'(1)) ? clk : phase_q;
endmodule

// File: rtl/cdc_clk_gate.sv
`timescale 1ps/1ps
module cdc_clk_gate #(
    parameter bit HAS_GATE = 1'b1
) (
    input  logic clk_in,
    input  logic rst,
    input  logic enable,
    output logic gate_on,
    output logic clk_out
);
    generate
        if (HAS_GATE) begin : g_gate
            logic en_q;
            // Enable is captured while the clock is low, so the AND never glitches.
            always_ff @(negedge clk_in) begin
                if (rst) en_q <= 1'b0;
                else     en_q <= enable;
            end
            assign gate_on = en_q;
            assign clk_out = clk_in & en_q;
        end else begin : g_nogate
            logic unused_gate;
            assign unused_gate = ^{rst, enable};
            assign gate_on     = 1'b1;
            assign clk_out     = clk_in;
        end
    endgenerate
endmodule

// File: rtl/clk_div_cell.sv
`timescale 1ps/1ps
module clk_div_cell
    import cdc_pkg::*;
#(
    parameter bit HAS_MUX  = 1'b1,
    parameter bit HAS_GATE = 1'b1,
    parameter int CNT_W    = RAT_W
) (
    input  logic             clk_pri,
    input  logic [N_SEC-1:0] clk_sec,
    input  logic             rst,
    input  logic             src_sw,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             div_sw,
    input  logic [2:0]       div_sel,
    input  logic             div3_sw,
    input  logic             enable,
    output logic             clk_out,
    output logic [RAT_W-1:0] ratio_o
);
    logic             clk_sel;
    logic             div_clk;
    logic             phase_q;
    logic             gate_on;
    logic [CNT_W-1:0] cnt_w;
    div_cfg_t         cfg;

    assign cfg = '{div3_on: div3_sw, div_on: div_sw, code: div_sel};

    cdc_src_mux #(.HAS_MUX(HAS_MUX)) u_mux (
        .clk_pri(clk_pri), .clk_sec(clk_sec), .src_sw(src_sw),
        .src_sel(src_sel), .clk_sel(clk_sel)
    );

    cdc_div_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk_sel), .rst(rst), .cfg(cfg), .cnt(cnt_w),
        .ratio(ratio_o), .phase_q(phase_q), .div_clk(div_clk)
    );

    cdc_clk_gate #(.HAS_GATE(HAS_GATE)) u_gate (
        .clk_in(div_clk), .rst(rst), .enable(enable),
        .gate_on(gate_on), .clk_out(clk_out)
    );
endmodule

// File: rtl/cdc_checker.sv
`timescale 1ps/1ps
module cdc_checker #(
    parameter int CNT_W = 4,
    parameter int RAT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic [RAT_W-1:0] ratio,
    input logic             q,
    input logic             gate_on,
    input logic             clk_out
);
    assert_ratio_legal_R3: assert property (@(posedge clk) disable iff (rst)
        ratio inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12});

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (CNT_W+1)'(cnt) < (CNT_W+1)'(ratio));

    assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (rst)
        ((CNT_W+1)'(cnt) + (CNT_W+1)'(1) < (CNT_W+1)'(ratio)) |=> $stable(ratio));

    assert_rise_at_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(q) |-> (cnt == '0));

    assert_gate_low_R8: assert property (@(posedge clk) disable iff (rst)
        !gate_on |-> !clk_out);
endmodule

bind clk_div_cell cdc_checker #(.CNT_W(CNT_W), .RAT_W(cdc_pkg::RAT_W)) u_chk (
    .clk(clk_sel), .rst(rst), .cnt(cnt_w), .ratio(ratio_o),
    .q(phase_q), .gate_on(gate_on), .clk_out(clk_out)
);

// File: tb/tb_clk_div_cell.sv
`timescale 1ps/1ps
module tb_clk_div_cell;
    typedef struct packed {
        logic        sw;
        logic [2:0]  sel;
        logic        dsw;
        logic [2:0]  dsel;
        logic        d3;
        logic [3:0]  rat;
        logic [15:0] src_ps;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 4'd1,  16'd8000},
        '{1'b0, 3'd5, 1'b1, 3'd1, 1'b0, 4'd2,  16'd8000},
        '{1'b0, 3'd0, 1'b1, 3'd2, 1'b0, 4'd4,  16'd8000},
        '{1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 4'd6,  16'd8000},
        '{1'b0, 3'd0, 1'b1, 3'd4, 1'b0, 4'd8,  16'd8000},
        '{1'b0, 3'd0, 1'b1, 3'd5, 1'b0, 4'd12, 16'd8000},
        '{1'b0, 3'd0, 1'b1, 3'd6, 1'b0, 4'd1,  16'd8000},
        '{1'b0, 3'd0, 1'b1, 3'd7, 1'b0, 4'd1,  16'd8000},
        '{1'b0, 3'd0, 1'b0, 3'd5, 1'b0, 4'd1,  16'd8000},
        '{1'b0, 3'd0, 1'b1, 3'd5, 1'b1, 4'd3,  16'd8000},
        '{1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 4'd3,  16'd8000},
        '{1'b1, 3'd0, 1'b1, 3'd1, 1'b0, 4'd2,  16'd10000},
        '{1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 4'd1,  16'd16000},
        '{1'b1, 3'd7, 1'b1, 3'd2, 1'b0, 4'd4,  16'd24000},
        '{1'b1, 3'd7, 1'b0, 3'd0, 1'b1, 4'd3,  16'd24000}
    };

    logic       clk_pri = 1'b0;
    wire  [7:0] clk_sec;
    logic       rst = 1'b1;
    logic       src_sw = 1'b0, div_sw = 1'b0, div3_sw = 1'b0, enable = 1'b0;
    logic [2:0] src_sel = 3'd0, div_sel = 3'd0;
    logic       clk_out, clk_out_min, use_min = 1'b0;
    logic [3:0] ratio_o, ratio_min;
    int         checks = 0, errors = 0;

    always #4000 clk_pri = ~clk_pri;   // 125 MHz

    for (genvar k = 0; k < 8; k++) begin : g_src
        logic c = 1'b0;
        always #(5000 + 1000 * k) c = ~c;   // period 10000 + 2000*k ps
        assign clk_sec[k] = c;
    end

    wire mclk = use_min ? clk_out_min : clk_out;

    clk_div_cell dut (
        .clk_pri(clk_pri), .clk_sec(clk_sec), .rst(rst), .src_sw(src_sw),
        .src_sel(src_sel), .div_sw(div_sw), .div_sel(div_sel),
        .div3_sw(div3_sw), .enable(enable), .clk_out(clk_out), .ratio_o(ratio_o)
    );

    clk_div_cell #(.HAS_MUX(1'b0), .HAS_GATE(1'b0)) dut_min (
        .clk_pri(clk_pri), .clk_sec(clk_sec), .rst(rst), .src_sw(src_sw),
        .src_sel(src_sel), .div_sw(div_sw), .div_sel(div_sel),
        .div3_sw(div3_sw), .enable(enable), .clk_out(clk_out_min), .ratio_o(ratio_min)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic measure(output longint per, output longint hi);
        longint t0, t1, t2;
        @(posedge mclk); t0 = $time;
        @(negedge mclk); t1 = $time;
        @(posedge mclk); t2 = $time;
        per = t2 - t0;
        hi  = t1 - t0;
    endtask

    task automatic settle();
        repeat (3) @(posedge mclk);
    endtask

    initial begin
        repeat (150000) @(posedge clk_pri);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint per, hi, exp_hi, t0, t1, t2;
        string  tag;
        bit     stuck;

        // R10: reset state
        repeat (6) @(posedge clk_pri);
        @(negedge clk_pri);
        chk(clk_out == 1'b0, "R10 clk_out in reset", longint'(clk_out), 0);
        chk(ratio_o == 4'd1, "R10 ratio_o in reset", longint'(ratio_o), 1);
        enable = 1'b1;
        rst    = 1'b0;

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            src_sw = VEC[i].sw;  src_sel = VEC[i].sel;
            div_sw = VEC[i].dsw; div_sel = VEC[i].dsel;
            div3_sw = VEC[i].d3;
            settle();
            measure(per, hi);
            #1000;
            if (VEC[i].d3)                     tag = "R4";
            else if (VEC[i].sw)                tag = "R2";
            else if (VEC[i].sel != 3'd0)       tag = "R1";
            else if (!VEC[i].dsw)              tag = "R5";
            else                               tag = "R3";
            chk(per == longint'(VEC[i].src_ps) * VEC[i].rat, {tag, " period"},
                per, longint'(VEC[i].src_ps) * VEC[i].rat);
            if (VEC[i].rat == 4'd1)      exp_hi = VEC[i].src_ps / 2;
            else if (VEC[i].rat == 4'd3) exp_hi = VEC[i].src_ps;
            else                         exp_hi = longint'(VEC[i].src_ps) * VEC[i].rat / 2;
            chk(hi == exp_hi, VEC[i].rat == 4'd3 ? "R4 high time" : "R6 high time", hi, exp_hi);
            chk(ratio_o == VEC[i].rat, "R3 ratio_o", longint'(ratio_o), longint'(VEC[i].rat));
        end

        // R7: change mid-period, old period completes
        src_sw = 1'b0; src_sel = 3'd0; div3_sw = 1'b0; div_sw = 1'b1; div_sel = 3'd5;
        settle();
        @(posedge clk_out); t0 = $time;
        repeat (3) @(posedge clk_pri);
        @(negedge clk_pri);
        div_sel = 3'd1;
        chk(ratio_o == 4'd12, "R7 ratio held mid-period", longint'(ratio_o), 12);
        @(posedge clk_out); t1 = $time;
        #1000;
        chk(t1 - t0 == 96000, "R7 spanning period", t1 - t0, 96000);
        chk(ratio_o == 4'd2, "R7 new ratio after boundary", longint'(ratio_o), 2);
        @(posedge clk_out); t2 = $time;
        chk(t2 - t1 == 16000, "R7 next period", t2 - t1, 16000);

        // R8: gate holds output low
        enable = 1'b0;
        repeat (40) @(posedge clk_pri);
        stuck = 1'b1;
        for (int j = 0; j < 24; j++) begin
            #1500;
            if (clk_out !== 1'b0) stuck = 1'b0;
        end
        chk(stuck, "R8 output low when disabled", longint'(!stuck), 0);
        enable = 1'b1;
        settle();
        measure(per, hi);
        chk(per == 16000, "R8 output resumes", per, 16000);

        // R9: reduced variant ignores source switch and enable
        use_min = 1'b1;
        enable = 1'b0; src_sw = 1'b1; src_sel = 3'd7; div_sel = 3'd2;
        settle();
        measure(per, hi);
        chk(per == 32000, "R9 primary only, always enabled", per, 32000);
        chk(hi == 16000, "R9 high time", hi, 16000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule